// File: doc/BRIEF.md
# SPI Serial-Clock Divider

This block derives the serial-clock timing of an SPI shift engine from the module clock. A 13-bit clock-control word picks one of two division laws. The linear law divides the module clock by 2×(N+1). The power-of-two law divides it by 2^M. For every serial-clock edge, rising or falling, the block emits a one-cycle enable pulse that the shift engine uses to launch or capture a bit. It also drives the divided clock as a level, for observation.

The shift engine holds `run_i` high for the whole of a burst. While `run_i` is low the divider is cleared. A change of the control word during a burst restarts the division from zero. After either event the first edge comes one full half-period after counting resumes, and the duty cycle is always 50%. Because both edges of the serial clock fall on module-clock cycles, the module clock must run at least twice the serial rate. A divide-by-1 setting is the only exception: it is turned into a pulse on every module-clock cycle.

Top module: `spi_clk_div`

## Requirements
- R1: Field positions in the control word: the linear divisor N is in bits 7:0, the exponent M is in bits 11:8, and the mode select is in bit 12 (1 selects linear, 0 selects power of two). The field of the mode that is not selected has no effect on timing.
- R2: In linear mode the edge pulses are N+1 module cycles apart, so the serial clock period is 2×(N+1) module cycles.
- R3: In power-of-two mode with M from 1 to 15, the edge pulses are 2^(M-1) module cycles apart, so the period is 2^M module cycles.
- R4: In power-of-two mode with M=0, the edge pulse is asserted on every module cycle of a running burst.
- R5: `tick_o` is high for exactly the cycles on which `sclk_o` changes while running. `sclk_o` alternates high, low, high and so on from a low start, which gives a 50% duty cycle.
- R6: While `run_i` is low, `tick_o` is low and `sclk_o` is low one cycle later. After `run_i` rises with a half-period of H cycles, the first pulse appears after the H-th rising edge at which `run_i` is sampled high.
- R7: A change of the control word while running suppresses the pulse on the next cycle, drives `sclk_o` low and restarts the count. The first pulse then comes H cycles after the restart edge, where H is the new half-period.
- R8: While `rst_ni` is low, `tick_o` and `sclk_o` are low.
- R9: The extreme settings N=255 (half-period 256) and M=15 (half-period 16384) produce the stated spacing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Burst active from the shift engine; low clears the divider |
| cfg_i | input | 13 | Control word: N[7:0], M[11:8], mode select[12] |
| tick_o | output | 1 | One-cycle pulse at each serial-clock edge |
| sclk_o | output | 1 | Divided clock level, low when idle |

## Verification
A counter that wraps at the wrong limit shows up as soon as the first pulse arrives: the pulse is a cycle early or late, and every later pulse keeps the same offset. A count that is not cleared at idle or on a control-word change shows up as a first pulse earlier than a full half-period. A level register that falls out of step with the pulses gives a wrong `sclk_o` value at the first pulse. The scoreboard records the exact cycle and level of every pulse, so any such fault appears on the first edge after the event.

// File: rtl/spi_clk_div_pkg.sv
package spi_clk_div_pkg;
  typedef enum logic {
    DIV_POW2 = 1'b0,
    DIV_LIN  = 1'b1
  } div_mode_e;
endpackage

// File: rtl/spi_clk_cfg_trk.sv
// Holds the control word in use; flags a restart whenever the input differs
module spi_clk_cfg_trk #(
  parameter int CFG_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             restart_o
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_i;
  end

  assign cfg_o     = cfg_q;
  assign restart_o = (cfg_i != cfg_q);
endmodule

// File: rtl/spi_clk_half_sel.sv
// Maps the active control word to a half-period limit (half-period minus one)
module spi_clk_half_sel
  import spi_clk_div_pkg::*;
#(
  parameter int NW = 8,
  parameter int MW = 4,
  parameter int CW = 15
) (
  input  logic [NW+MW:0] cfg_i,
  output logic [CW-1:0]  lim_o
);
  localparam int NEXP = 1 << MW;

  logic [NW-1:0] n_div;
  logic [MW-1:0] m_exp;
  div_mode_e     mode;
  logic [CW-1:0] pow_tab [NEXP];
  logic [CW-1:0] lin_lim;

  assign n_div = cfg_i[NW-1:0];
  assign m_exp = cfg_i[NW+MW-1:NW];
  assign mode  = div_mode_e'(cfg_i[NW+MW]);

  for (genvar e = 0; e < NEXP; e++) begin : g_pow
    if (e == 0) begin : g_one
      assign pow_tab[e] = '0;   // divide by 1 folds onto a pulse every cycle
    end else begin : g_shift
      assign pow_tab[e] = CW'((64'd1 << (e - 1)) - 64'd1);
    end
  end

  assign lin_lim = CW'(n_div);
  assign lim_o   = (mode == DIV_LIN) ? lin_lim : pow_tab[m_exp];
endmodule

// File: rtl/spi_clk_cnt.sv
module spi_clk_cnt #(
  parameter int CW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          restart_i,
  input  logic [CW-1:0] lim_i,
  output logic          tick_o,
  output logic          lvl_o
);
  logic [CW-1:0] cnt_q;
  logic          tick_q, lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
      lvl_q  <= 1'b0;
    end else if (!run_i || restart_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
      lvl_q  <= 1'b0;
    end else if (cnt_q >= lim_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
      lvl_q  <= ~lvl_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;
  assign lvl_o  = lvl_q;
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int NW = 8,
  parameter int MW = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [NW+MW:0]   cfg_i,
  output logic             tick_o,
  output logic             sclk_o
);
  localparam int CFG_W = NW + MW + 1;
  localparam int POW_W = (1 << MW) - 1;
  localparam int CW    = (NW > POW_W) ? NW : POW_W;

  logic [CFG_W-1:0] cfg_act;
  logic             restart;
  logic [CW-1:0]    lim;

  spi_clk_cfg_trk #(.CFG_W(CFG_W)) u_trk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_i     (cfg_i),
    .cfg_o     (cfg_act),
    .restart_o (restart)
  );

  spi_clk_half_sel #(.NW(NW), .MW(MW), .CW(CW)) u_sel (
    .cfg_i (cfg_act),
    .lim_o (lim)
  );

  spi_clk_cnt #(.CW(CW)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .restart_i (restart),
    .lim_i     (lim),
    .tick_o    (tick_o),
    .lvl_o     (sclk_o)
  );
endmodule

// File: rtl/spi_clk_div_chk.sv
module spi_clk_div_chk #(
  parameter int NW = 8,
  parameter int MW = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           run_i,
  input logic [NW+MW:0] cfg_i,
  input logic           tick_o,
  input logic           sclk_o
);
  AST_IDLE_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!tick_o && !sclk_o)); // R6

  AST_TICK_MOVES_SCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (sclk_o != $past(sclk_o))); // R5

  AST_SCLK_ONLY_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_o && sclk_o) |-> $past(sclk_o)); // R5

  AST_DIV1_EVERY_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(rst_ni) && $stable(cfg_i) && !cfg_i[NW+MW] &&
     (cfg_i[NW+MW-1:NW] == '0)) |=> tick_o); // R4

  AST_CFG_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(rst_ni) && !$stable(cfg_i)) |=> (!tick_o && !sclk_o)); // R7

  always @(negedge clk_i) begin
    if (!rst_ni) AST_RESET_QUIET: assert (!tick_o && !sclk_o); // R8
  end
endmodule

bind spi_clk_div spi_clk_div_chk #(.NW(NW), .MW(MW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .run_i  (run_i),
  .cfg_i  (cfg_i),
  .tick_o (tick_o),
  .sclk_o (sclk_o)
);

// File: tb/spi_clk_div_tb.sv
module spi_clk_div_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b0;
  logic [12:0] cfg_i = '0;
  logic        tick_o, sclk_o;

  spi_clk_div u_dut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .cfg_i  (cfg_i),
    .tick_o (tick_o),
    .sclk_o (sclk_o)
  );

  always #2 clk = ~clk;  // 250 MHz

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int unsigned at;
    logic        lvl;
    string       req;
  } exp_t;

  exp_t q[$];
  exp_t mon_e;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [12:0] mk(input bit lin, input int n, input int m);
    return {lin, 4'(m), 8'(n)};
  endfunction

  // monitor: every pulse must match the head of the queue in cycle and level
  always @(negedge clk) begin
    if (rst_ni && tick_o) begin
      if (q.size() == 0) begin
        chk(1'b0, "R5", "unexpected tick at cycle", cyc, 0);
      end else begin
        mon_e = q.pop_front();
        chk(cyc == mon_e.at, mon_e.req, "tick cycle", cyc, mon_e.at);
        chk(sclk_o == mon_e.lvl, "R5", "sclk level at tick", sclk_o, mon_e.lvl);
      end
    end
  end

  task automatic push_ticks(input int unsigned base, input int half, input int k,
                            input bit first_lvl, input string req);
    for (int j = 1; j <= k; j++) begin
      exp_t e;
      e.at  = base + j * half;
      e.lvl = ((j % 2) == 1) ? first_lvl : ~first_lvl;
      e.req = req;
      q.push_back(e);
    end
  endtask

  task automatic wait_cyc(input int unsigned t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic end_burst(input string req);
    run_i = 1'b0;
    @(negedge clk);
    chk(sclk_o == 1'b0, "R6", "idle sclk", sclk_o, 0);
    chk(tick_o == 1'b0, "R6", "idle tick", tick_o, 0);
    @(negedge clk);
    chk(q.size() == 0, req, "missing ticks", q.size(), 0);
    q.delete();
  endtask

  task automatic burst(input logic [12:0] c, input int half, input int k,
                       input string req);
    int unsigned c0;
    @(negedge clk);
    cfg_i = c;
    repeat (3) @(negedge clk);
    c0 = cyc;
    push_ticks(c0, half, k, 1'b1, req);
    run_i = 1'b1;
    wait_cyc(c0 + k * half);
    end_burst(req);
  endtask

  initial begin
    int unsigned c0;
    int unsigned c1;
    run_i = 1'b1;
    cfg_i = mk(1, 0, 0);
    repeat (4) @(negedge clk);
    chk(tick_o == 1'b0, "R8", "reset tick", tick_o, 0);
    chk(sclk_o == 1'b0, "R8", "reset sclk", sclk_o, 0);
    run_i = 1'b0;
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    burst(mk(1, 0, 0), 1, 5, "R2");
    burst(mk(1, 3, 0), 4, 3, "R2");
    burst(mk(1, 2, 15), 3, 3, "R1");     // exponent field ignored in linear mode
    burst(mk(0, 0, 0), 1, 5, "R4");
    burst(mk(0, 0, 1), 1, 3, "R3");
    burst(mk(0, 0, 4), 8, 3, "R3");
    burst(mk(0, 200, 3), 4, 3, "R1");    // divisor field ignored in power-of-two mode

    // R6: stop mid half-period, then a restart needs a full half-period
    @(negedge clk);
    cfg_i = mk(1, 3, 0);
    repeat (3) @(negedge clk);
    c0 = cyc;
    push_ticks(c0, 4, 1, 1'b1, "R6");
    run_i = 1'b1;
    wait_cyc(c0 + 6);
    end_burst("R6");
    burst(mk(1, 3, 0), 4, 3, "R6");

    // R7: control word changes during a burst
    @(negedge clk);
    cfg_i = mk(1, 3, 0);
    repeat (3) @(negedge clk);
    c0 = cyc;
    push_ticks(c0, 4, 1, 1'b1, "R7");
    run_i = 1'b1;
    wait_cyc(c0 + 6);
    cfg_i = mk(1, 1, 0);
    c1 = c0 + 7;
    push_ticks(c1, 2, 3, 1'b1, "R7");
    wait_cyc(c1 + 6);
    end_burst("R7");

    burst(mk(1, 255, 0), 256, 3, "R9");
    burst(mk(0, 0, 15), 16384, 3, "R9");

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule